// File: doc/BRIEF.md
# Host-Bus Receive FIFO Read Port

This block is the read side of an asynchronous, SRAM-style host bus slave, placed in a fast internal clock domain. The host lowers an active-low chip select and an active-low read strobe in either order; the block brings both through two-flop synchronizers. It treats the moment both are seen low as the start of a read and the moment either is seen high again as its end. At the start it latches the address and a FIFO-select input. With FIFO-select high, the upper address bits are ignored and the access always reads the head of the receive data FIFO. This lets a host whose address increments during a burst keep draining the same FIFO. With FIFO-select low, the address goes to an external register-read interface instead.

Reads can be full 32-bit words, or 16-bit halves chosen by the lowest address bit. The FIFO advances with a one-cycle pop pulse when a cycle ends, but only when that cycle consumed the last part of the head word. A read of an empty FIFO returns zero, leaves the FIFO alone and raises a sticky underrun flag. Three pulse outputs report host cycles that break the minimum cycle time, strobe-low width or strobe-high width. Each limit is given in nanoseconds and converted to internal clocks from the clock frequency parameter.

Top module: `hfifo_rd_port`

## Requirements
- R1: A read is active only while both synchronized cs_n and rd_n are low, whichever fell first; it ends when either returns high. data_oe is high exactly while a read is active.
- R2: With fifo_sel high at read start, addr[6:1] (host address bits 7..2 beyond bit 1) do not change the returned data, and reg_rd stays low.
- R3: In 32-bit mode (dword_mode=1) with fifo_sel high and a non-empty FIFO, rdata equals fifo_head, and fifo_pop pulses for exactly one clock at the end of the cycle.
- R4: In 16-bit mode (dword_mode=0), addr[0] (host address bit 1) = 0 returns {16'h0, fifo_head[15:0]} without a pop; addr[0] = 1 returns {16'h0, fifo_head[31:16]} and pops at cycle end.
- R5: rdata is captured when the read starts and holds steady while data_oe is high, even if fifo_head changes.
- R6: A direct FIFO read while fifo_empty is high returns zero, does not pop, and sets underrun; underrun stays set until underrun_clr is high in a cycle where no new underrun occurs (a new underrun wins over a clear in the same cycle).
- R7: With fifo_sel low at read start, reg_rd pulses for one clock with reg_addr equal to addr, rdata then equals reg_rdata, and the FIFO is not popped.
- R8: Back-to-back reads that meet the timing limits are each served and each pop once, with no error pulse.
- R9: err_short_asrt pulses when a read stays active fewer than ceil(T_ASRT_NS*CLK_MHZ/1000) clocks (default 32 ns).
- R10: err_short_deasrt pulses when the idle gap between two reads is shorter than ceil(T_DEASRT_NS*CLK_MHZ/1000) clocks (default 13 ns).
- R11: err_short_cyc pulses when two read starts lie fewer than ceil(T_CYC_NS*CLK_MHZ/1000) clocks apart (default 165 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| fifo_sel | input | 1 | High selects direct FIFO reading |
| addr | input | AW (7) | Host address bits 7..1; addr[0] is bit 1 |
| dword_mode | input | 1 | 1: 32-bit reads, 0: 16-bit reads |
| fifo_head | input | DW (32) | Word at the head of the receive FIFO |
| fifo_empty | input | 1 | Receive FIFO holds no word |
| fifo_pop | output | 1 | One-clock pulse advancing the FIFO |
| reg_rd | output | 1 | One-clock register read request |
| reg_addr | output | AW (7) | Address latched for the register read |
| reg_rdata | input | DW (32) | Register data, valid while reg_rd is high |
| rdata | output | DW (32) | Data for the host bus |
| data_oe | output | 1 | Tri-state driver enable for rdata |
| underrun | output | 1 | Sticky empty-read flag |
| underrun_clr | input | 1 | Clears underrun |
| err_short_cyc | output | 1 | Pulse: read cycle time too short |
| err_short_asrt | output | 1 | Pulse: strobes low too briefly |
| err_short_deasrt | output | 1 | Pulse: strobes high too briefly |

## Verification
Setting underrun and clearing it can fall in the same clock. The bench holds underrun_clr high across a whole read of an empty FIFO, so the clear is present on the edge where the read starts. It then counts the clocks in which underrun is high. A new underrun must win over the clear, so exactly one such clock is expected: the flag appears on the start edge and the still-present clear removes it on the next. Zero clocks means the clear won, and more than one means the clear was ignored.

// File: rtl/hfifo_rd_port.sv
module hfifo_rd_port #(
  parameter int CLK_MHZ     = 100,
  parameter int T_CYC_NS    = 165,
  parameter int T_ASRT_NS   = 32,
  parameter int T_DEASRT_NS = 13,
  parameter int DW          = 32,
  parameter int AW          = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          fifo_sel,
  input  logic [AW-1:0] addr,
  input  logic          dword_mode,
  input  logic [DW-1:0] fifo_head,
  input  logic          fifo_empty,
  output logic          fifo_pop,
  output logic          reg_rd,
  output logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] rdata,
  output logic          data_oe,
  output logic          underrun,
  input  logic          underrun_clr,
  output logic          err_short_cyc,
  output logic          err_short_asrt,
  output logic          err_short_deasrt
);

  localparam int HW       = DW / 2;
  localparam int MIN_CYC  = (T_CYC_NS * CLK_MHZ + 999) / 1000;
  localparam int MIN_ASRT = (T_ASRT_NS * CLK_MHZ + 999) / 1000;
  localparam int MIN_DEA  = (T_DEASRT_NS * CLK_MHZ + 999) / 1000;
  localparam int CW       = $clog2(MIN_CYC + MIN_ASRT + MIN_DEA + 2) + 1;
  localparam logic [CW-1:0] LIM_CYC  = CW'(MIN_CYC);
  localparam logic [CW-1:0] LIM_ASRT = CW'(MIN_ASRT);
  localparam logic [CW-1:0] LIM_DEA  = CW'(MIN_DEA);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [1:0]    cs_sy, rd_sy;
  logic          act, act_q, start, fin;
  logic          pop_pend, seen;
  logic [AW-1:0] cap_addr;
  logic [CW-1:0] asrt_cnt, dea_cnt, cyc_cnt;
  logic [HW-1:0] half;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy <= 2'b11;
      rd_sy <= 2'b11;
      act_q <= 1'b0;
    end else begin
      cs_sy <= {cs_sy[0], cs_n};
      rd_sy <= {rd_sy[0], rd_n};
      act_q <= act;
    end

  assign act      = ~cs_sy[1] & ~rd_sy[1];
  assign start    = act & ~act_q;
  assign fin      = ~act & act_q;
  assign data_oe  = act_q;
  assign fifo_pop = fin & pop_pend;
  assign reg_addr = cap_addr;
  assign half     = addr[0] ? fifo_head[DW-1:HW] : fifo_head[HW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata    <= '0;
      cap_addr <= '0;
      pop_pend <= 1'b0;
      reg_rd   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      reg_rd <= start & ~fifo_sel;
      if (start) begin
        cap_addr <= addr;
        if (!fifo_sel) begin
          pop_pend <= 1'b0;
        end else if (fifo_empty) begin
          rdata    <= '0;
          pop_pend <= 1'b0;
        end else begin
          rdata    <= dword_mode ? fifo_head : {{HW{1'b0}}, half};
          pop_pend <= dword_mode | addr[0];
        end
      end else if (reg_rd) begin
        rdata <= reg_rdata;
      end
      if (start && fifo_sel && fifo_empty) underrun <= 1'b1;
      else if (underrun_clr)               underrun <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      asrt_cnt         <= '0;
      dea_cnt          <= '0;
      cyc_cnt          <= '0;
      seen             <= 1'b0;
      err_short_cyc    <= 1'b0;
      err_short_asrt   <= 1'b0;
      err_short_deasrt <= 1'b0;
    end else begin
      if (start)                      asrt_cnt <= ONE;
      else if (act && asrt_cnt != '1) asrt_cnt <= asrt_cnt + ONE;
      if (fin)                        dea_cnt <= ONE;
      else if (!act && dea_cnt != '1) dea_cnt <= dea_cnt + ONE;
      if (start)                      cyc_cnt <= ONE;
      else if (cyc_cnt != '1)         cyc_cnt <= cyc_cnt + ONE;
      if (start) seen <= 1'b1;
      err_short_asrt   <= fin && (asrt_cnt < LIM_ASRT);
      err_short_deasrt <= start && seen && (dea_cnt < LIM_DEA);
      err_short_cyc    <= start && seen && (cyc_cnt < LIM_CYC);
    end

  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fifo_pop |=> !fifo_pop); // R3
  AST_POP_CLOSES_OE: assert property (@(posedge clk) disable iff (!rst_n) fifo_pop |=> !data_oe); // R1
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe) && !$past(reg_rd)) |-> $stable(rdata)); // R5
  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> (data_oe && rdata == '0)); // R6
  AST_REG_NO_POP: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |-> !fifo_pop); // R7
  AST_ASRT_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) err_short_asrt |-> !data_oe); // R9

endmodule

// File: tb/hfifo_rd_port_tb_top.sv
module hfifo_rd_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, fifo_sel = 1'b0, dword_mode = 1'b1;
  logic [6:0]  addr = '0;
  logic [31:0] fifo_head = '0;
  logic        fifo_empty = 1'b0, underrun_clr = 1'b0;
  logic        fifo_pop, reg_rd, data_oe, underrun;
  logic        err_short_cyc, err_short_asrt, err_short_deasrt;
  logic [6:0]  reg_addr, last_raddr;
  logic [31:0] reg_rdata, rdata;
  int checks = 0, fails = 0;
  int pops = 0, regs = 0, e_cyc = 0, e_asrt = 0, e_dea = 0, ur_hi = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign reg_rdata = {8'h5A, 16'h0000, 1'b0, reg_addr};

  hfifo_rd_port #(.CLK_MHZ(50), .T_DEASRT_NS(50)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .fifo_sel(fifo_sel),
    .addr(addr), .dword_mode(dword_mode), .fifo_head(fifo_head),
    .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .rdata(rdata),
    .data_oe(data_oe), .underrun(underrun), .underrun_clr(underrun_clr),
    .err_short_cyc(err_short_cyc), .err_short_asrt(err_short_asrt),
    .err_short_deasrt(err_short_deasrt));

  always @(posedge clk) begin
    if (fifo_pop) pops++;
    if (reg_rd) begin regs++; last_raddr <= reg_addr; end
    if (err_short_cyc) e_cyc++;
    if (err_short_asrt) e_asrt++;
    if (err_short_deasrt) e_dea++;
    if (underrun) ur_hi++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act_v, exp_v);
    end
  endtask

  task automatic strobe(input int hold, input int gap);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    repeat (hold) @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  typedef struct packed {
    logic        fsel;
    logic [6:0]  a;
    logic        dw;
    logic [31:0] head;
    logic        empty;
    logic [31:0] exp;
    logic        pop;
    logic        rg;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 7'h00, 1'b1, 32'h11223344, 1'b0, 32'h11223344, 1'b1, 1'b0},
    '{1'b1, 7'h7C, 1'b1, 32'hDEADBEEF, 1'b0, 32'hDEADBEEF, 1'b1, 1'b0},
    '{1'b1, 7'h40, 1'b0, 32'hCAFEF00D, 1'b0, 32'h0000F00D, 1'b0, 1'b0},
    '{1'b1, 7'h41, 1'b0, 32'hCAFEF00D, 1'b0, 32'h0000CAFE, 1'b1, 1'b0},
    '{1'b1, 7'h3F, 1'b0, 32'h12345678, 1'b0, 32'h00001234, 1'b1, 1'b0},
    '{1'b0, 7'h33, 1'b1, 32'hFFFFFFFF, 1'b0, 32'h5A000033, 1'b0, 1'b1},
    '{1'b0, 7'h01, 1'b0, 32'hFFFFFFFF, 1'b0, 32'h5A000001, 1'b0, 1'b1},
    '{1'b1, 7'h00, 1'b1, 32'h99999999, 1'b1, 32'h00000000, 1'b0, 1'b0}
  };

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int p0, r0;
    repeat (3) @(negedge clk);
    chk(data_oe == 0 && fifo_pop == 0 && reg_rd == 0, "R1 reset idle", {29'b0, data_oe, fifo_pop, reg_rd}, 0);
    chk(rdata == 0, "R5 reset rdata", rdata, 0);
    chk(underrun == 0, "R6 reset underrun", underrun, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    foreach (VECS[i]) begin
      fifo_sel = VECS[i].fsel; addr = VECS[i].a; dword_mode = VECS[i].dw;
      fifo_head = VECS[i].head; fifo_empty = VECS[i].empty;
      p0 = pops; r0 = regs;
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
      repeat (5) @(negedge clk);
      chk(data_oe == 1, "R1 oe during read", data_oe, 1);
      chk(rdata == VECS[i].exp, VECS[i].rg ? "R7 reg data" : (VECS[i].empty ? "R6 empty zero" :
          (VECS[i].dw ? "R3/R2 word data" : "R4 half data")), rdata, VECS[i].exp);
      fifo_head = ~fifo_head;
      repeat (3) @(negedge clk);
      chk(rdata == VECS[i].exp, "R5 held", rdata, VECS[i].exp);
      cs_n = 1'b1; rd_n = 1'b1;
      repeat (8) @(negedge clk);
      chk(data_oe == 0, "R1 oe released", data_oe, 0);
      chk(pops - p0 == int'(VECS[i].pop), "R3/R4 pop count", pops - p0, VECS[i].pop);
      chk(regs - r0 == int'(VECS[i].rg), "R2/R7 reg_rd count", regs - r0, VECS[i].rg);
      if (VECS[i].rg) chk(last_raddr == VECS[i].a, "R7 reg_addr", last_raddr, VECS[i].a);
      if (VECS[i].empty) chk(underrun == 1, "R6 underrun set", underrun, 1);
    end
    fifo_empty = 1'b0;

    @(negedge clk); underrun_clr = 1'b1;
    @(negedge clk); underrun_clr = 1'b0;
    chk(underrun == 0, "R6 cleared", underrun, 0);

    // R6 set wins over simultaneous clear
    fifo_sel = 1'b1; fifo_empty = 1'b1; ur_hi = 0; underrun_clr = 1'b1;
    p0 = pops;
    strobe(10, 8);
    underrun_clr = 1'b0;
    chk(ur_hi == 1, "R6 set beats clear", ur_hi, 1);
    chk(pops == p0, "R6 no pop on empty", pops - p0, 0);
    fifo_empty = 1'b0;

    // R1 ordering: cs first, rd released first
    fifo_sel = 1'b1; dword_mode = 1'b1; fifo_head = 32'hA0A0A0A0; p0 = pops;
    @(negedge clk); cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(data_oe == 0, "R1 cs alone", data_oe, 0);
    rd_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(data_oe == 1, "R1 cs then rd", data_oe, 1);
    rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(data_oe == 0 && pops == p0 + 1, "R1 end by rd", pops - p0, 1);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 ordering: rd first, cs released first
    rd_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(data_oe == 0, "R1 rd alone", data_oe, 0);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(data_oe == 1, "R1 rd then cs", data_oe, 1);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(data_oe == 0 && pops == p0 + 2, "R1 end by cs", pops - p0, 2);
    rd_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(e_cyc + e_asrt + e_dea == 0, "R8 no false error", e_cyc + e_asrt + e_dea, 0);

    // R8 back-to-back
    p0 = pops;
    for (int k = 0; k < 4; k++) strobe(10, 3);
    repeat (6) @(negedge clk);
    chk(pops - p0 == 4, "R8 burst pops", pops - p0, 4);
    chk(e_cyc + e_asrt + e_dea == 0, "R8 burst clean", e_cyc + e_asrt + e_dea, 0);

    fifo_sel = 1'b0;
    // R9 short assertion
    strobe(1, 15);
    chk(e_asrt == 1 && e_dea == 0 && e_cyc == 0, "R9 short assert", e_asrt, 1);
    // R10 short deassertion
    strobe(10, 1);
    strobe(10, 15);
    chk(e_dea == 1 && e_cyc == 0 && e_asrt == 1, "R10 short deassert", e_dea, 1);
    // R11 short cycle
    strobe(10, 3);
    strobe(3, 3);
    strobe(10, 15);
    chk(e_cyc == 1 && e_dea == 1 && e_asrt == 1, "R11 short cycle", e_cyc, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule